// File: doc/BRIEF.md
# Four-Channel DAC Host Register Block

This block sits between a byte-wide host register port and four 12-bit digital-to-analog converters. Software writes each channel's code as two bytes. The low byte is staged first. The high byte then carries the top four bits of the code and completes the write. A shared range register selects one of four output spans per channel. A one-bit mode control chooses between two ways of loading new codes: each channel loads on its own high-byte write, or all channels load together when software writes a trigger offset. A read-only location returns a 4-bit identifier taken from external switches.

The block drives registered 12-bit codes, 2-bit range codes and a one-cycle load strobe per channel toward the converters. A warm-reset input is qualified by a strap. With the strap high, a warm reset is ignored, so the outputs, ranges and all internal state carry on. With the strap low, a warm reset restores the default state, exactly like a cold reset. The cold reset is synchronous and active-high, and it always restores the defaults.

Top module: `dac_regif`

## Requirements
- R1: After cold reset (`rst`), every channel code is 0, every range field is 0 (unipolar 5 V), mode control reads 0 (immediate) and no load strobe is active, whatever `keep_strap` is.
- R2: A write to offset 2c (c = 0..3) only stages the low byte of channel c. No code changes and no load strobe fires.
- R3: In immediate mode, a write to offset 2c+1 sets channel c's code to {wdata[3:0], staged low byte} on the next clock. `dac_load` bit c alone pulses for that one cycle. wdata[7:4] is ignored.
- R4: In synchronized mode, a write to offset 2c+1 loads only channel c's holding register. Codes and strobes are unchanged.
- R5: In synchronized mode, any write to offset 0x09 moves all four holding values to the codes in one cycle and pulses every `dac_load` bit for one cycle. In immediate mode such a write changes nothing.
- R6: Offset 0x08 is the range register. Channel c's field is bits [2c+1:2c], with 0 = unipolar 5 V, 1 = unipolar 10 V, 2 = bipolar 5 V and 3 = bipolar 10 V. A write drives `dac_range` on the next clock, and the register reads back as written.
- R7: Offset 0x0F is mode control. Bit 0 = 1 selects synchronized mode. A read returns bit 0, with the other bits 0.
- R8: A read of offset 0x14 returns {4'b0, board_sw}.
- R9: A read of any other offset, including the data offsets 0x00 to 0x07 and 0x09, returns 0x00.
- R10: A warm reset with `keep_strap` = 1 leaves codes, ranges, mode, staged and holding data untouched.
- R11: A warm reset with `keep_strap` = 0 restores the R1 state, and bus writes in that cycle are dropped.
- R12: `bus_rdata` is registered. It shows the addressed value in the cycle after `bus_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Cold reset, synchronous, active-high |
| warm_rst | input | 1 | Warm reset request, qualified by `keep_strap` |
| keep_strap | input | 1 | 1 = warm reset keeps state, 0 = warm reset restores defaults |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| board_sw | input | 4 | Board identifier switches |
| dac_code | output | 48 | Channel codes, channel c in bits [12c+11:12c] |
| dac_range | output | 8 | Range codes, channel c in bits [2c+1:2c] |
| dac_load | output | 4 | One-cycle load strobe per channel |

## Verification
Every result takes effect one clock after the stimulus edge. The new code, the range, the load strobe and the read data are all visible between that edge and the next. The strobe returns low one edge later. The bench drives each operation on a falling edge and lets exactly one rising edge pass. It then compares every output with its model on the next falling edge, so a strobe that lasts too long or fires late shows up as a mismatch on the following operation. Warm resets, mode switches and trigger writes are mixed in with the random traffic. As a result, the sync-mode hold path, the ignored trigger in immediate mode and both strap settings all meet non-trivial staged state.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;
  // Register offsets whose positions software depends on
  localparam int unsigned OFS_RANGE = 8;
  localparam int unsigned OFS_TRIG  = 9;
  localparam int unsigned OFS_MODE  = 15;
  localparam int unsigned OFS_ID    = 20;

  typedef enum logic [1:0] {
    RNG_UNI5  = 2'd0,
    RNG_UNI10 = 2'd1,
    RNG_BIP5  = 2'd2,
    RNG_BIP10 = 2'd3
  } range_e;
endpackage

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int CODE_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              trig,
  input  logic              sync_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [CODE_W-1:0] code,
  output logic              load
);
  localparam int HI_W = CODE_W - DATA_W;

  logic [DATA_W-1:0] stage_lo;
  logic [CODE_W-1:0] hold;
  logic [CODE_W-1:0] assembled;

  assign assembled = {wdata[HI_W-1:0], stage_lo};

  always_ff @(posedge clk) begin
    if (clr) begin
      stage_lo <= '0;
      hold     <= '0;
      code     <= '0;
      load     <= 1'b0;
    end else begin
      load <= 1'b0;
      if (wr_lo) stage_lo <= wdata;
      if (wr_hi) begin
        if (sync_mode) begin
          hold <= assembled;
        end else begin
          code <= assembled;
          load <= 1'b1;
        end
      end
      if (trig && sync_mode) begin
        code <= hold;
        load <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_ctrl.sv
module dac_ctrl
  import dac_regif_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_range,
  input  logic              wr_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [2*NCH-1:0]  range_q,
  output logic              sync_q
);
  localparam int RW = 2 * NCH;

  always_ff @(posedge clk) begin
    if (clr) begin
      range_q <= {NCH{RNG_UNI5}};
      sync_q  <= 1'b0;
    end else begin
      if (wr_range) range_q <= wdata[RW-1:0];
      if (wr_mode)  sync_q  <= wdata[0];
    end
  end
endmodule

// File: rtl/dac_regif.sv
module dac_regif
  import dac_regif_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 12,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int ID_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  warm_rst,
  input  logic                  keep_strap,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [ID_W-1:0]       board_sw,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic [2*NCH-1:0]      dac_range,
  output logic [NCH-1:0]        dac_load
);
  localparam int RW = 2 * NCH;

  logic clr;
  logic sync_q;
  logic [RW-1:0] range_q;
  logic trig;

  assign clr  = rst | (warm_rst & ~keep_strap);
  assign trig = bus_wr && (bus_addr == ADDR_W'(OFS_TRIG));

  dac_ctrl #(.NCH(NCH), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .clr      (clr),
    .wr_range (bus_wr && (bus_addr == ADDR_W'(OFS_RANGE))),
    .wr_mode  (bus_wr && (bus_addr == ADDR_W'(OFS_MODE))),
    .wdata    (bus_wdata),
    .range_q  (range_q),
    .sync_q   (sync_q)
  );

  assign dac_range = range_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dac_chan #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_chan (
      .clk       (clk),
      .clr       (clr),
      .wr_lo     (bus_wr && (bus_addr == ADDR_W'(2 * c))),
      .wr_hi     (bus_wr && (bus_addr == ADDR_W'(2 * c + 1))),
      .trig      (trig),
      .sync_mode (sync_q),
      .wdata     (bus_wdata),
      .code      (dac_code[c*CODE_W +: CODE_W]),
      .load      (dac_load[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == ADDR_W'(OFS_RANGE))
        bus_rdata <= DATA_W'(range_q);
      else if (bus_addr == ADDR_W'(OFS_MODE))
        bus_rdata <= DATA_W'(sync_q);
      else if (bus_addr == ADDR_W'(OFS_ID))
        bus_rdata <= DATA_W'(board_sw);
      else
        bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/dac_regif_chk.sv
module dac_regif_chk
  import dac_regif_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  warm_rst,
  input logic                  keep_strap,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  sync_q,
  input logic [NCH*CODE_W-1:0] dac_code,
  input logic [2*NCH-1:0]      dac_range,
  input logic [NCH-1:0]        dac_load
);
  localparam int CW = $clog2(NCH);

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  logic clr_c, data_sel, hi_sel, lo_sel;
  assign clr_c    = rst | (warm_rst & ~keep_strap);
  assign data_sel = bus_addr < ADDR_W'(2 * NCH);
  assign hi_sel   = data_sel && bus_addr[0];
  assign lo_sel   = data_sel && !bus_addr[0];

  assert_cold_defaults_R1: assert property (@(posedge clk)
    (primed && $past(rst)) |-> (dac_code == '0 && dac_range == '0 && dac_load == '0));

  assert_lo_stage_only_R2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && !clr_c && lo_sel) |-> (dac_load == '0 && $stable(dac_code)));

  assert_imm_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && !clr_c && hi_sel && !sync_q)
      |-> (dac_load == (NCH'(1) << $past(bus_addr[CW:1]))));

  assert_sync_hold_only_R4: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && !clr_c && hi_sel && sync_q) |-> (dac_load == '0 && $stable(dac_code)));

  assert_trig_all_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && !clr_c && bus_addr == ADDR_W'(OFS_TRIG) && sync_q) |-> (&dac_load));

  assert_strobe_shape_R5: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(dac_load) || (&dac_load)));

  assert_warm_keep_R10: assert property (@(posedge clk) disable iff (rst)
    $past(warm_rst && keep_strap && !bus_wr && !rst) |-> ($stable(dac_code) && $stable(dac_range)));

  assert_warm_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $past(warm_rst && !keep_strap && !rst) |-> (dac_code == '0 && dac_range == '0 && dac_load == '0));
endmodule

bind dac_regif dac_regif_chk #(.NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .warm_rst   (warm_rst),
  .keep_strap (keep_strap),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .sync_q     (sync_q),
  .dac_code   (dac_code),
  .dac_range  (dac_range),
  .dac_load   (dac_load)
);

// File: tb/tb_dac_regif.sv
`timescale 1ns/1ps
module tb_dac_regif;
  localparam int NCH = 4, CODE_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic warm_rst = 1'b0, keep_strap = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] board_sw = 4'h0;
  logic [NCH*CODE_W-1:0] dac_code;
  logic [2*NCH-1:0] dac_range;
  logic [NCH-1:0] dac_load;

  always #2.5 clk = ~clk;

  dac_regif dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0]  m_lo   [NCH];
  logic [11:0] m_hold [NCH];
  logic [11:0] m_code [NCH];
  logic [7:0]  m_rng;
  logic        m_sync;
  logic [3:0]  e_load;
  logic [7:0]  e_rd;

  function automatic logic [NCH*CODE_W-1:0] flat_code();
    logic [NCH*CODE_W-1:0] f;
    for (int i = 0; i < NCH; i++) f[i*CODE_W +: CODE_W] = m_code[i];
    return f;
  endfunction

  function automatic logic [7:0] read_exp(input logic [4:0] a);
    case (a)
      5'd8:    return m_rng;
      5'd15:   return {7'd0, m_sync};
      5'd20:   return {4'd0, board_sw};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NCH; i++) begin m_lo[i] = 0; m_hold[i] = 0; m_code[i] = 0; end
    m_rng = 0; m_sync = 0;
  endtask

  // Drive one operation on a falling edge, check on the next falling edge.
  task automatic step(input bit wr, input bit rd, input logic [4:0] a, input logic [7:0] d,
                      input bit warm, input bit keep, input string tag);
    int c;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    warm_rst = warm; keep_strap = keep;
    e_load = '0;
    if (rd) e_rd = read_exp(a);
    if (warm && !keep) model_clear();
    else if (wr) begin
      c = int'(a >> 1);
      if (a < 5'd8) begin
        if (!a[0]) m_lo[c] = d;
        else if (m_sync) m_hold[c] = {d[3:0], m_lo[c]};
        else begin m_code[c] = {d[3:0], m_lo[c]}; e_load[c] = 1'b1; end
      end else if (a == 5'd8) m_rng = d;
      else if (a == 5'd15) m_sync = d[0];
      else if (a == 5'd9 && m_sync) begin
        for (int i = 0; i < NCH; i++) m_code[i] = m_hold[i];
        e_load = '1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; warm_rst = 0;
    check(tag, "code", 64'(dac_code), 64'(flat_code()));
    check(tag, "range", 64'(dac_range), 64'(m_rng));
    check(tag, "load", 64'(dac_load), 64'(e_load));
    if (rd) check({tag, "/R12"}, "rdata", 64'(bus_rdata), 64'(e_rd));
  endtask

  function automatic string rd_tag(input logic [4:0] a);
    if (a == 5'd8) return "R6";
    if (a == 5'd15) return "R7";
    if (a == 5'd20) return "R8";
    return "R9";
  endfunction

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    e_rd = 0;
    keep_strap = 1'b1;
    repeat (3) @(negedge clk);
    // R1: cold reset defaults, even with keep strap high
    check("R1", "code", 64'(dac_code), 64'd0);
    check("R1", "range", 64'(dac_range), 64'd0);
    check("R1", "load", 64'(dac_load), 64'd0);
    rst = 0;
    step(0, 1, 5'd15, 0, 0, 0, "R1");

    // R2/R3 directed: every channel, upper nibble junk
    for (int c = 0; c < NCH; c++) begin
      step(1, 0, 5'(2*c), 8'(8'h31 + c), 0, 0, "R2");
      step(1, 0, 5'(2*c+1), 8'hF0 | 8'(c + 9), 0, 0, "R3");
    end
    // R6 range and readback
    step(1, 0, 5'd8, 8'b11_10_01_00, 0, 0, "R6");
    step(0, 1, 5'd8, 0, 0, 0, "R6");
    // R5 trigger in immediate mode has no effect
    step(1, 0, 5'd9, 8'hFF, 0, 0, "R5");
    // R7/R4/R5 synchronized sequence
    step(1, 0, 5'd15, 8'hFF, 0, 0, "R7");
    step(0, 1, 5'd15, 0, 0, 0, "R7");
    step(1, 0, 5'd2, 8'hAB, 0, 0, "R2");
    step(1, 0, 5'd3, 8'h0C, 0, 0, "R4");
    step(1, 0, 5'd7, 8'h05, 0, 0, "R4");
    step(1, 0, 5'd9, 8'h00, 0, 0, "R5");
    step(0, 0, 5'd0, 0, 0, 0, "R5");
    // R10 keep, R11 clear
    step(0, 0, 5'd0, 0, 1, 1, "R10");
    step(0, 1, 5'd15, 0, 0, 0, "R10");
    step(1, 0, 5'd8, 8'h5A, 1, 0, "R11");
    step(0, 1, 5'd15, 0, 0, 0, "R11");
    // R8/R9 reads
    board_sw = 4'hA;
    step(0, 1, 5'd20, 0, 0, 0, "R8");
    step(0, 1, 5'd1, 0, 0, 0, "R9");
    step(0, 1, 5'd9, 0, 0, 0, "R9");

    // Random traffic
    for (int n = 0; n < 1500; n++) begin
      int op = int'($urandom % 16);
      int c = int'($urandom % NCH);
      logic [7:0] d = 8'($urandom);
      logic [4:0] a;
      board_sw = 4'($urandom);
      if (op < 4)       step(1, 0, 5'(2*c), d, 0, 0, "R2");
      else if (op < 8)  step(1, 0, 5'(2*c+1), d, 0, 0, m_sync ? "R4" : "R3");
      else if (op < 9)  step(1, 0, 5'd8, d, 0, 0, "R6");
      else if (op < 10) step(1, 0, 5'd15, d, 0, 0, "R7");
      else if (op < 12) step(1, 0, 5'd9, d, 0, 0, "R5");
      else if (op < 15) begin
        a = ($urandom % 2) ? 5'($urandom) : (($urandom % 2) ? 5'd8 : 5'd20);
        step(0, 1, a, 0, 0, 0, rd_tag(a));
      end else begin
        bit k = 1'($urandom);
        step(0, 0, 5'd0, 0, 1, k, k ? "R10" : "R11");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule